// File: doc/BRIEF.md
# Serial-Programmed Output Channel Control Bank

This block sits on the command side of a sixteen-channel low-side switch controller. A host writes it over a four-wire serial bus (clock idle low, data sampled on the rising clock edge, active-low chip select). Every frame is 24 bits long. The leading 8 bits name a command and the trailing 16 bits hold one bit per channel. A frame takes effect only when chip select returns high after exactly 24 clock edges. The serial pins are oversampled by the block's own system clock, so the serial clock must be several system clocks slower.

Six 16-bit control registers are held here: channel on/off, PWM enable, AND/OR combine mode, fast-shutdown mode, open-load current enable and global shutdown. Each channel's gate enable is its on/off bit, optionally merged with a shared PWM input pin. Whether the pin is merged, and whether by AND or by OR, is chosen per channel. A soft-reset command clears the first four registers and leaves the last two alone. The hardware reset clears all six.

Top module: `outdrv_cmd_ctrl`

## Requirements
- R1: A frame is shifted in most significant bit first while `cs_n` is low, one bit per rising `sclk` edge. Its first 8 bits are the command and its last 16 bits are data, with data bit i belonging to channel i. It is acted on after `cs_n` rises.
- R2: A frame whose count of rising `sclk` edges while `cs_n` was low is anything other than 24 changes no register.
- R3: Write commands replace a whole register with the data field. The codes are: 0x01 on/off, 0x02 fast-shutdown mode (`fsd_mode`), 0x03 PWM enable, 0x04 AND/OR mode, 0x05 open-load enable (`ol_en`) and 0x06 global shutdown (`gsd_en`).
- R4: A channel whose PWM enable bit is 0 drives `gate_en[i]` equal to its on/off bit, whatever `pwm_in` and its AND/OR bit are.
- R5: A channel with PWM enable 1 and AND/OR bit 0 drives `gate_en[i]` as its on/off bit AND the synchronized `pwm_in`.
- R6: A channel with PWM enable 1 and AND/OR bit 1 drives `gate_en[i]` as its on/off bit OR the synchronized `pwm_in`.
- R7: `pwm_in` passes through two flip-flops before the gating. A change at the pin shows on `gate_en` after the second following rising edge of `clk`.
- R8: While `rst_n` is low, all six registers are zero, so `gate_en`, `fsd_mode`, `ol_en` and `gsd_en` are all zero.
- R9: Command 0x07 (soft reset) clears the on/off, fast-shutdown, PWM enable and AND/OR registers, whatever its data field holds, so every `gate_en` bit goes to 0.
- R10: The soft reset leaves `ol_en` and `gsd_en` unchanged.
- R11: A complete frame with any code other than 0x01 to 0x07 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| pwm_in | input | 1 | Shared asynchronous PWM pin |
| gate_en | output | 16 | Per-channel gate-drive enables |
| fsd_mode | output | 16 | Fast-shutdown mode per channel |
| ol_en | output | 16 | Open-load current enable per channel |
| gsd_en | output | 16 | Global shutdown register contents |

## Verification
The hardest condition to reach is a soft reset landing while the two registers it must spare hold non-zero values. At the same moment the pin-driven channels must be in OR mode with `pwm_in` high, so that a wrong clear would show up on the outputs. The stimulus first loads every register with distinct patterns, holds `pwm_in` high and only then sends the soft reset. It also sends 23-bit and 25-bit frames and unknown codes before that point, to show that none of them disturbed the loaded state.

// File: rtl/odc_pkg.sv
package odc_pkg;
   localparam int CMD_W = 8;

   typedef enum logic [CMD_W-1:0] {
      OP_ONOFF = 8'h01,
      OP_FSD   = 8'h02,
      OP_PWMEN = 8'h03,
      OP_ANDOR = 8'h04,
      OP_OLEN  = 8'h05,
      OP_GSD   = 8'h06,
      OP_SRST  = 8'h07
   } odc_op_e;

   function automatic logic odc_op_known(input logic [CMD_W-1:0] code);
      return (code >= 8'h01) && (code <= 8'h07);
   endfunction
endpackage

// File: rtl/odc_sync.sv
module odc_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 1,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("odc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/odc_spi_rx.sv
module odc_spi_rx #(
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               cs_n_s,
   input  logic               mosi_s,
   output logic               frame_vld,
   output logic [FRAME_W-1:0] frame
);
   localparam int CNT_W   = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("odc_spi_rx: FRAME_W too small");
   end

   logic               sclk_d, cs_d;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] shreg;
   logic               sclk_rise, cs_fall, cs_rise;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign cs_fall   = ~cs_n_s & cs_d;
   assign cs_rise   = cs_n_s & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         cs_d      <= 1'b1;
         bit_cnt   <= '0;
         shreg     <= '0;
         frame_vld <= 1'b0;
      end else begin
         sclk_d    <= sclk_s;
         cs_d      <= cs_n_s;
         frame_vld <= cs_rise && (bit_cnt == CNT_FULL);
         if (cs_fall) begin
            bit_cnt <= '0;
         end else if (!cs_n_s && sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], mosi_s};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign frame = shreg;
endmodule

// File: rtl/odc_regbank.sv
module odc_regbank
   import odc_pkg::*;
#(
   parameter int CH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_vld,
   input  logic [CMD_W-1:0] wr_cmd,
   input  logic [CH-1:0]    wr_data,
   output logic [CH-1:0]    on_q,
   output logic [CH-1:0]    fsd_q,
   output logic [CH-1:0]    pwm_q,
   output logic [CH-1:0]    andor_q,
   output logic [CH-1:0]    ol_q,
   output logic [CH-1:0]    gsd_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q    <= '0;
         fsd_q   <= '0;
         pwm_q   <= '0;
         andor_q <= '0;
         ol_q    <= '0;
         gsd_q   <= '0;
      end else if (wr_vld) begin
         case (wr_cmd)
            OP_ONOFF: on_q    <= wr_data;
            OP_FSD:   fsd_q   <= wr_data;
            OP_PWMEN: pwm_q   <= wr_data;
            OP_ANDOR: andor_q <= wr_data;
            OP_OLEN:  ol_q    <= wr_data;
            OP_GSD:   gsd_q   <= wr_data;
            OP_SRST: begin
               on_q    <= '0;
               fsd_q   <= '0;
               pwm_q   <= '0;
               andor_q <= '0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/odc_gate.sv
module odc_gate #(
   parameter int CH       = 16,
   parameter bit GATE_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CH-1:0] on_q,
   input  logic [CH-1:0] pwm_q,
   input  logic [CH-1:0] andor_q,
   input  logic          pwm_s,
   output logic [CH-1:0] gate
);
   logic [CH-1:0] mix;

   for (genvar i = 0; i < CH; i++) begin : g_ch
      logic merged;
      assign merged = andor_q[i] ? (on_q[i] | pwm_s) : (on_q[i] & pwm_s);
      assign mix[i] = pwm_q[i] ? merged : on_q[i];
   end

   if (GATE_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gate <= '0;
         else        gate <= mix;
      end
   end else begin : g_comb
      assign gate = mix;
   end
endmodule

// File: rtl/outdrv_cmd_ctrl.sv
module outdrv_cmd_ctrl
   import odc_pkg::*;
#(
   parameter int CH          = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit GATE_REG    = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk,
   input  logic          cs_n,
   input  logic          mosi,
   input  logic          pwm_in,
   output logic [CH-1:0] gate_en,
   output logic [CH-1:0] fsd_mode,
   output logic [CH-1:0] ol_en,
   output logic [CH-1:0] gsd_en
);
   localparam int FRAME_W = CMD_W + CH;

   if (CH < 1 || CH > 32) begin : g_bad_ch
      $error("outdrv_cmd_ctrl: CH out of range");
   end

   logic             sclk_s, cs_n_s, mosi_s, pwm_s;
   logic             frame_vld;
   logic [FRAME_W-1:0] frame;
   logic [CMD_W-1:0] cmd_f;
   logic [CH-1:0]    data_f;
   logic [CH-1:0]    on_r, fsd_r, pwm_r, andor_r, ol_r, gsd_r;

   odc_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_spi_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sclk, cs_n, mosi}),
      .q({sclk_s, cs_n_s, mosi_s})
   );

   odc_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b0)) u_pwm_sync (
      .clk(clk), .rst_n(rst_n), .d(pwm_in), .q(pwm_s)
   );

   odc_spi_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
      .frame_vld(frame_vld), .frame(frame)
   );

   assign cmd_f  = frame[FRAME_W-1 -: CMD_W];
   assign data_f = frame[CH-1:0];

   odc_regbank #(.CH(CH)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_vld(frame_vld), .wr_cmd(cmd_f), .wr_data(data_f),
      .on_q(on_r), .fsd_q(fsd_r), .pwm_q(pwm_r),
      .andor_q(andor_r), .ol_q(ol_r), .gsd_q(gsd_r)
   );

   odc_gate #(.CH(CH), .GATE_REG(GATE_REG)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .on_q(on_r), .pwm_q(pwm_r), .andor_q(andor_r),
      .pwm_s(pwm_s), .gate(gate_en)
   );

   assign fsd_mode = fsd_r;
   assign ol_en    = ol_r;
   assign gsd_en   = gsd_r;
endmodule

// File: rtl/odc_chk.sv
module odc_chk
   import odc_pkg::*;
#(
   parameter int CH       = 16,
   parameter bit GATE_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_vld,
   input logic [CMD_W-1:0] cmd_f,
   input logic             pwm_s,
   input logic [CH-1:0]    gate,
   input logic [CH-1:0]    on_r,
   input logic [CH-1:0]    fsd_r,
   input logic [CH-1:0]    pwm_r,
   input logic [CH-1:0]    andor_r,
   input logic [CH-1:0]    ol_r,
   input logic [CH-1:0]    gsd_r
);
   if (!GATE_REG) begin : g_gate_props
      a_r4_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
         ((gate ^ on_r) & ~pwm_r) == '0);
      a_r5_and_blocks: assert property (@(posedge clk) disable iff (!rst_n)
         !pwm_s |-> ((gate & pwm_r & ~andor_r) == '0));
      a_r6_or_forces: assert property (@(posedge clk) disable iff (!rst_n)
         pwm_s |-> ((gate & pwm_r & andor_r) == (pwm_r & andor_r)));
   end

   a_r2_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |=> ($stable(on_r) && $stable(fsd_r) && $stable(pwm_r) &&
                      $stable(andor_r) && $stable(ol_r) && $stable(gsd_r)));

   a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && cmd_f == OP_SRST) |=>
         ((on_r | fsd_r | pwm_r | andor_r) == '0));

   a_r10_soft_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && cmd_f == OP_SRST) |=> ($stable(ol_r) && $stable(gsd_r)));

   a_r11_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && !odc_op_known(cmd_f)) |=>
         ($stable(on_r) && $stable(fsd_r) && $stable(pwm_r) &&
          $stable(andor_r) && $stable(ol_r) && $stable(gsd_r)));
endmodule

bind outdrv_cmd_ctrl odc_chk #(.CH(CH), .GATE_REG(GATE_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .cmd_f(cmd_f),
   .pwm_s(pwm_s), .gate(gate_en), .on_r(on_r), .fsd_r(fsd_r),
   .pwm_r(pwm_r), .andor_r(andor_r), .ol_r(ol_r), .gsd_r(gsd_r)
);

// File: tb/tb_outdrv_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_outdrv_cmd_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, pwm_in = 1'b0;
   logic [15:0] gate_en, fsd_mode, ol_en, gsd_en;

   outdrv_cmd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .pwm_in(pwm_in), .gate_en(gate_en), .fsd_mode(fsd_mode),
      .ol_en(ol_en), .gsd_en(gsd_en)
   );

   always #2 clk = ~clk;

   int checks = 0, errors = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;
   string cur_req = "R8";

   logic [15:0] m_on, m_fsd, m_pwm, m_ao, m_ol, m_gsd;
   logic        ps1, ps2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin ps1 <= 1'b0; ps2 <= 1'b0; end
      else begin ps2 <= ps1; ps1 <= pwm_in; end
   end

   function automatic logic [15:0] exp_gate();
      logic [15:0] g;
      for (int i = 0; i < 16; i++) begin
         if (!m_pwm[i])     g[i] = m_on[i];
         else if (m_ao[i])  g[i] = m_on[i] | ps2;
         else               g[i] = m_on[i] & ps2;
      end
      return g;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk({cur_req, " gate_en"}, gate_en, exp_gate());
         chk({cur_req, " fsd_mode"}, fsd_mode, m_fsd);
         chk({cur_req, " ol_en"}, ol_en, m_ol);
         chk({cur_req, " gsd_en"}, gsd_en, m_gsd);
      end
   end

   task automatic model_clear_all();
      m_on = '0; m_fsd = '0; m_pwm = '0; m_ao = '0; m_ol = '0; m_gsd = '0;
   endtask

   task automatic model_apply(input logic [7:0] c, input logic [15:0] d);
      case (c)
         8'h01: m_on  = d;
         8'h02: m_fsd = d;
         8'h03: m_pwm = d;
         8'h04: m_ao  = d;
         8'h05: m_ol  = d;
         8'h06: m_gsd = d;
         8'h07: begin m_on = '0; m_fsd = '0; m_pwm = '0; m_ao = '0; end
         default: ;
      endcase
   endtask

   // R1: MSB first, command then data; commit after cs_n rises
   task automatic send(input logic [7:0] c, input logic [15:0] d, input int nbits);
      logic [23:0] w;
      w = {c, d};
      @(negedge clk); cs_n = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 24) ? w[23-i] : 1'b1;
         repeat (3) @(negedge clk);
         sclk = 1'b1;
         repeat (3) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (3) @(negedge clk);
      cmp_en = 1'b0;
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      if (nbits == 24) model_apply(c, d);
      cmp_en = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wiggle(input int n, input int seed);
      int s;
      s = seed;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         s = (s * 1103515245 + 12345) & 32'h7fffffff;
         pwm_in = s[16];
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic hw_reset();
      cmp_en = 1'b0;
      @(negedge clk); rst_n = 1'b0;
      model_clear_all();
      repeat (2) @(negedge clk);
      chk("R8 gate_en in reset", gate_en, 16'h0000);
      chk("R8 fsd_mode in reset", fsd_mode, 16'h0000);
      chk("R8 ol_en in reset", ol_en, 16'h0000);
      chk("R8 gsd_en in reset", gsd_en, 16'h0000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      cmp_en = 1'b1;
   endtask

   initial begin
      model_clear_all();
      hw_reset();

      cur_req = "R1 R3 R4";
      send(8'h01, 16'hA5C3, 24);
      wiggle(20, 7);
      chk("R4 on/off without PWM", gate_en, 16'hA5C3);

      cur_req = "R5 R6 R7";
      send(8'h03, 16'h00FF, 24);
      send(8'h04, 16'h0F0F, 24);
      wiggle(60, 99);
      @(negedge clk); pwm_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 AND ch4-7 low, R6 OR ch0-3 pin low", gate_en, 16'hA503);
      pwm_in = 1'b1;
      @(negedge clk);
      chk("R7 one clk after pin rise unchanged", gate_en, 16'hA503);
      @(negedge clk);
      chk("R7 two clks after pin rise applied", gate_en, 16'hA5CF);

      cur_req = "R3";
      send(8'h02, 16'h1234, 24);
      send(8'h05, 16'hBEEF, 24);
      send(8'h06, 16'h0F00, 24);
      chk("R3 fsd_mode write", fsd_mode, 16'h1234);
      chk("R3 ol_en write", ol_en, 16'hBEEF);

      cur_req = "R2";
      send(8'h01, 16'h0000, 23);
      chk("R2 23-bit frame ignored", gate_en, 16'hA5CF);
      send(8'h02, 16'h0000, 25);
      chk("R2 25-bit frame ignored", fsd_mode, 16'h1234);

      cur_req = "R11";
      send(8'h3C, 16'hFFFF, 24);
      send(8'h00, 16'h0000, 24);
      send(8'hFF, 16'h0000, 24);
      chk("R11 unknown code left gate_en", gate_en, 16'hA5CF);
      chk("R11 unknown code left gsd_en", gsd_en, 16'h0F00);

      cur_req = "R9 R10";
      pwm_in = 1'b1;
      send(8'h07, 16'hFFFF, 24);
      chk("R9 soft reset gate_en off", gate_en, 16'h0000);
      chk("R9 soft reset fsd_mode", fsd_mode, 16'h0000);
      chk("R10 ol_en kept", ol_en, 16'hBEEF);
      chk("R10 gsd_en kept", gsd_en, 16'h0F00);
      send(8'h01, 16'hFFFF, 24);
      send(8'h03, 16'hFFFF, 24);
      @(negedge clk); pwm_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 AND/OR cleared to AND mode", gate_en, 16'h0000);
      wiggle(30, 5);

      cur_req = "R8";
      hw_reset();
      repeat (5) @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule